// File: doc/BRIEF.md
# Shared Timebase Counter with Per-Target Compare Interrupts

This block keeps one free-running counter that all targets share, and it gives each target its own 64-bit compare register. A target's timer interrupt latches once the counter reaches that target's compare value. The interrupt stays latched until software writes the compare register again. The counter is `32 + 4*CNT_FIELD` bits wide, and `CNT_FIELD` is shown in the configuration register. A stop bit halts the counter. While the counter is halted, software may preload it.

Software reads the counter as two 32-bit words and gets a coherent value with a high, low, high sequence, repeated until both high reads agree. For this to work, the upper word only advances as a carry out of the lower word. Every access carries a requester index. Two compare windows are provided. The local window reaches the requester's own compare register. The remote window reaches the target named in the requester's own remote-select register.

Top module: `tick_cmp_top`

## Requirements
- R1: Reset puts the block in this state: counter zero and stopped, every compare register zero, every remote-select register zero, every enable zero, and no interrupt. The counter stays at zero until the stop bit is cleared.
- R2: Config (word 0) bit 0 is the stop bit, and it resets to 1. While it is 1 the counter holds its value. While it is 0 the counter advances by one per clock, starting from the held value. A write that clears the bit at edge E gives its first increment at edge E+1.
- R3: Config bits [11:8] read back `CNT_FIELD`, and the other config bits read zero. The count-high word (word 2) returns counter bits above 31 in its low `4*CNT_FIELD` bits, and its remaining bits read zero, even after a write that sets them.
- R4: Count-low (word 1) returns counter bits [31:0]. The high part changes only when it is loaded, or when the low word advances from all ones.
- R5: Writes to words 1 and 2 load the counter only while it is stopped. While it is running they are ignored.
- R6: Words 4 and 5 write and read the low and high halves of the requester's own compare register. An armed target whose counter is greater than or equal to its compare value latches its pending bit at the next edge.
- R7: A pending bit stays set until either half of that target's compare register is written, and that write clears it.
- R8: Word 7 bit 0 is the requester's interrupt enable. The interrupt output equals pending AND enable. Pending latches whether or not the enable is set.
- R9: A write to a compare low half disarms the target. Only the next write to the high half re-arms it, so no match is taken on a half-written value.
- R10: Word 6 is the requester's own remote-select register. Words 8 and 9 reach the low and high compare halves of the target it names. Other requesters' selections are unaffected.
- R11: The counter wraps to zero after its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 4 | Word index into the register window |
| bus_src | input | TGT_W | Index of the requesting target |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` and `bus_src`, combinational |
| tmr_irq | output | NTGT | Per-target timer interrupt |

## Verification
Carry logic that drifts upward by itself shows up on the count-high word within one clock of the low word passing any value other than all ones. The table rows load values just below the carry and wrap points so that this is exposed. A stuck or mis-set pending or armed flag shows on `tmr_irq` one edge after a compare write. The bench samples the interrupt in that cycle and again several cycles later. A wrong remote-select decode lands data in the wrong compare slot, which the bench sees immediately when it reads back through the local window of each target.

// File: rtl/tick_cmp_pkg.sv
// Package: register word map and config field positions shared by the
// counter-compare block and its bench.
package tick_cmp_pkg;

    typedef enum logic [3:0] {
        REG_CFG     = 4'd0,
        REG_CNT_LO  = 4'd1,
        REG_CNT_HI  = 4'd2,
        REG_CMP_LO  = 4'd4,
        REG_CMP_HI  = 4'd5,
        REG_OSEL    = 4'd6,
        REG_IEN     = 4'd7,
        REG_OCMP_LO = 4'd8,
        REG_OCMP_HI = 4'd9
    } reg_sel_e;

    localparam int CFG_STOP_BIT  = 0;
    localparam int CFG_FIELD_LSB = 8;

endpackage

// File: rtl/tick_counter.sv
// tick_counter: shared counter split into a 32-bit low word and a HW-bit
// high part that advances only on carry out of the low word.
// Assumes: HW between 4 and 32; load strobes come from a decoded bus write.
module tick_counter #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_stop,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [31:0]   lo_d,
    input  logic [HW-1:0] hi_d,
    output logic          stop_q,
    output logic [31:0]   lo_q,
    output logic [HW-1:0] hi_q
);

    logic carry;

    // carry into the high part when the low word rolls over while running
    assign carry = !stop_q && (lo_q == '1);

    // stop bit register, set on reset
    always_ff @(posedge clk) begin
        if (!rst_n)      stop_q <= 1'b1;
        else if (cfg_wr) stop_q <= cfg_stop;
    end

    // low word: count while running, load only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)              lo_q <= '0;
        else if (!stop_q)        lo_q <= lo_q + 32'd1;
        else if (ld_lo)          lo_q <= lo_d;
    end

    // high part: advance on carry, load only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)              hi_q <= '0;
        else if (carry)          hi_q <= hi_q + 1'b1;
        else if (stop_q && ld_hi) hi_q <= hi_d;
    end

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !ld_lo && !ld_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    p_run_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_q) |=> (lo_q == $past(lo_q) + 32'd1));

    p_carry_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(stop_q && ld_hi) && (stop_q || lo_q != '1)) |=> $stable(hi_q));

endmodule

// File: rtl/tick_compare_slot.sv
// tick_compare_slot: one target's 64-bit compare register, arm flag,
// latched pending bit and interrupt enable.
// Assumes: at most one of wr_lo / wr_hi is active in a cycle.
module tick_compare_slot (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic        wr_en,
    input  logic        en_d,
    input  logic [31:0] wdata,
    input  logic [63:0] cnt,
    output logic [63:0] cmp_q,
    output logic        en_q,
    output logic        irq
);

    logic armed_q;
    logic pend_q;
    logic reached;
    logic cmp_wr;

    assign reached = (cnt >= cmp_q);
    assign cmp_wr  = wr_lo || wr_hi;
    assign irq     = pend_q && en_q;

    // compare halves; low write disarms, high write re-arms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q   <= '0;
            armed_q <= 1'b0;
        end else if (wr_lo) begin
            cmp_q[31:0] <= wdata;
            armed_q     <= 1'b0;
        end else if (wr_hi) begin
            cmp_q[63:32] <= wdata;
            armed_q      <= 1'b1;
        end
    end

    // pending latch: set on armed match, cleared by any compare write
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_q <= 1'b0;
        else if (cmp_wr)            pend_q <= 1'b0;
        else if (armed_q && reached) pend_q <= 1'b1;
    end

    // interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_en) en_q <= en_d;
    end

    p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && reached && !cmp_wr) |=> pend_q);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !pend_q);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !cmp_wr) |=> pend_q);

    p_no_fire_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !pend_q) |=> !pend_q);

endmodule

// File: rtl/tick_cmp_top.sv
// tick_cmp_top: register window over the shared counter, one compare slot
// per target, and a remote-select register per requester.
// Assumes: NTGT >= 2, CNT_FIELD in 1..8; reads are combinational.
module tick_cmp_top
    import tick_cmp_pkg::*;
#(
    parameter int NTGT      = 4,
    parameter int CNT_FIELD = 4,
    localparam int TGT_W    = $clog2(NTGT),
    localparam int HW       = 4 * CNT_FIELD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [TGT_W-1:0] bus_src,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [NTGT-1:0]  tmr_irq
);

    reg_sel_e        sel;
    logic            stop_q;
    logic [31:0]     cnt_lo;
    logic [HW-1:0]   cnt_hi;
    logic [63:0]     cnt_full;
    logic [TGT_W-1:0] osel_q [NTGT];
    logic [63:0]     cmp_q [NTGT];
    logic [NTGT-1:0] en_q;

    assign sel      = reg_sel_e'(bus_addr);
    assign cnt_full = 64'({cnt_hi, cnt_lo});

    tick_counter #(.HW(HW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (bus_wr && sel == REG_CFG),
        .cfg_stop (bus_wdata[CFG_STOP_BIT]),
        .ld_lo    (bus_wr && sel == REG_CNT_LO),
        .ld_hi    (bus_wr && sel == REG_CNT_HI),
        .lo_d     (bus_wdata),
        .hi_d     (bus_wdata[HW-1:0]),
        .stop_q   (stop_q),
        .lo_q     (cnt_lo),
        .hi_q     (cnt_hi)
    );

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        logic own;
        logic rem;
        assign own = (bus_src == TGT_W'(t));
        assign rem = (osel_q[bus_src] == TGT_W'(t));

        // per-requester remote-select register
        always_ff @(posedge clk) begin
            if (!rst_n)                          osel_q[t] <= '0;
            else if (bus_wr && own && sel == REG_OSEL) osel_q[t] <= bus_wdata[TGT_W-1:0];
        end

        tick_compare_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (bus_wr && ((own && sel == REG_CMP_LO) || (rem && sel == REG_OCMP_LO))),
            .wr_hi (bus_wr && ((own && sel == REG_CMP_HI) || (rem && sel == REG_OCMP_HI))),
            .wr_en (bus_wr && own && sel == REG_IEN),
            .en_d  (bus_wdata[0]),
            .wdata (bus_wdata),
            .cnt   (cnt_full),
            .cmp_q (cmp_q[t]),
            .en_q  (en_q[t]),
            .irq   (tmr_irq[t])
        );
    end

    // read multiplexer keyed by word index and requester
    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_CFG:     bus_rdata = (32'(CNT_FIELD) << CFG_FIELD_LSB) | (32'(stop_q) << CFG_STOP_BIT);
            REG_CNT_LO:  bus_rdata = cnt_lo;
            REG_CNT_HI:  bus_rdata = 32'(cnt_hi);
            REG_CMP_LO:  bus_rdata = cmp_q[bus_src][31:0];
            REG_CMP_HI:  bus_rdata = cmp_q[bus_src][63:32];
            REG_OSEL:    bus_rdata = 32'(osel_q[bus_src]);
            REG_IEN:     bus_rdata = 32'(en_q[bus_src]);
            REG_OCMP_LO: bus_rdata = cmp_q[osel_q[bus_src]][31:0];
            REG_OCMP_HI: bus_rdata = cmp_q[osel_q[bus_src]][63:32];
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/test_tick_cmp_top.sv
`timescale 1ns/1ps
// Bench: table-driven counter load/run vectors, then directed reset,
// stop, compare, mask and remote-window tests.
module test_tick_cmp_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [1:0]  bus_src;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  tmr_irq;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    tick_cmp_top #(.NTGT(4), .CNT_FIELD(4)) i_tick_cmp_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_src(bus_src), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_irq(tmr_irq)
    );

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] n;
        logic [31:0] elo;
        logic [31:0] ehi;
    } vec_t;

    // load lo/hi, run n clocks, expect elo/ehi (high part is 16 bits)
    localparam vec_t TBL [5] = '{
        '{32'h0000_0000, 32'h0000_0000, 32'd5,  32'h0000_0005, 32'h0000_0000},
        '{32'hFFFF_FFFE, 32'h0000_0000, 32'd3,  32'h0000_0001, 32'h0000_0001},
        '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'd1,  32'h0000_0000, 32'h0000_0000},
        '{32'hFFFF_FFF0, 32'h0000_0012, 32'd32, 32'h0000_0010, 32'h0000_0013},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'd1,  32'h0000_0001, 32'h0000_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; write lands on the following posedge
    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        bus_addr = a; bus_src = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] v);
        bus_addr = a; bus_src = s; bus_wr = 1'b0;
        #0.5;
        v = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_src = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, 2'd0, v); check("R1 cfg reset", v, 32'h0000_0401);
        rd(4'd1, 2'd0, v); check("R1 count low", v, 32'd0);
        rd(4'd5, 2'd3, v); check("R1 compare high tgt3", v, 32'd0);
        check("R1 irq", 32'(tmr_irq), 32'd0);
        repeat (6) @(negedge clk);
        rd(4'd1, 2'd0, v); check("R1 stays stopped", v, 32'd0);

        // table: R2 R4 R11 R3
        for (int i = 0; i < 5; i++) begin
            wr(4'd1, 2'd0, TBL[i].lo);
            wr(4'd2, 2'd0, TBL[i].hi);
            wr(4'd0, 2'd0, 32'd0);
            for (int k = 1; k < int'(TBL[i].n); k++) @(negedge clk);
            wr(4'd0, 2'd0, 32'd1);
            rd(4'd1, 2'd0, v); check($sformatf("R2 R4 R11 row%0d low", i), v, TBL[i].elo);
            rd(4'd2, 2'd0, v); check($sformatf("R3 R4 row%0d high", i), v, TBL[i].ehi);
        end

        // R2 hold while stopped
        rd(4'd1, 2'd0, v);
        repeat (10) @(negedge clk);
        rd(4'd1, 2'd0, v2); check("R2 hold", v2, v);

        // R5 load ignored while running
        wr(4'd1, 2'd0, 32'd100);
        wr(4'd2, 2'd0, 32'd0);
        wr(4'd0, 2'd0, 32'd0);
        rd(4'd0, 2'd0, v); check("R3 cfg running", v, 32'h0000_0400);
        wr(4'd1, 2'd0, 32'd0);
        wr(4'd0, 2'd0, 32'd1);
        rd(4'd1, 2'd0, v); check("R5 write ignored", v, 32'd102);

        // compare on stopped counter = 1000
        wr(4'd1, 2'd0, 32'd1000);
        wr(4'd7, 2'd0, 32'd1);
        wr(4'd4, 2'd0, 32'd500);
        repeat (2) @(negedge clk);
        check("R9 low write disarms", 32'(tmr_irq[0]), 32'd0);
        wr(4'd5, 2'd0, 32'd0);
        check("R6 one-cycle latency", 32'(tmr_irq[0]), 32'd0);
        @(negedge clk);
        check("R6 fires", 32'(tmr_irq[0]), 32'd1);
        repeat (5) @(negedge clk);
        check("R7 holds", 32'(tmr_irq[0]), 32'd1);
        wr(4'd5, 2'd0, 32'd1);
        check("R7 cleared", 32'(tmr_irq[0]), 32'd0);
        repeat (3) @(negedge clk);
        check("R7 stays clear", 32'(tmr_irq[0]), 32'd0);
        rd(4'd5, 2'd0, v); check("R6 readback high", v, 32'd1);

        // R8 mask
        wr(4'd4, 2'd1, 32'd0);
        wr(4'd5, 2'd1, 32'd0);
        repeat (2) @(negedge clk);
        check("R8 masked", 32'(tmr_irq[1]), 32'd0);
        wr(4'd7, 2'd1, 32'd1);
        check("R8 pending kept", 32'(tmr_irq[1]), 32'd1);

        // R10 remote window
        wr(4'd6, 2'd0, 32'd2);
        wr(4'd8, 2'd0, 32'd7);
        wr(4'd9, 2'd0, 32'd0);
        rd(4'd4, 2'd2, v); check("R10 target2 low", v, 32'd7);
        rd(4'd8, 2'd0, v); check("R10 remote read", v, 32'd7);
        rd(4'd4, 2'd0, v); check("R10 own untouched", v, 32'd500);
        rd(4'd6, 2'd0, v); check("R10 select read", v, 32'd2);
        rd(4'd6, 2'd1, v); check("R10 other select", v, 32'd0);
        check("R10 irq other targets", 32'(tmr_irq), 32'b0010);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule